// File: doc/BRIEF.md
# Optical Slot Timing Sequencer

This block schedules the light pulses and sample strobes of a two-colour optical pulse sensing front end. A single cycle counter steps through equal-width slots. In the red slot the red LED enable is high. The slot after it is LED-off and provides an ambient reference. The infrared slot follows, and an optional second LED-off slot can close the cycle. Inside every slot the sequencer fires a one-clock ADC trigger at a programmed offset and tags it with the slot it belongs to. Red and infrared triggers sit at the same offset. The ambient triggers are held back until a turn-off guard interval has run out.

Interval settings are counted in clock cycles. The sequencer checks them when it starts, and a set that cannot fit the settle time, the sample and a margin inside a slot is refused. An accepted set is captured, so later changes on the inputs only matter at the next start. A warning flag goes with any trigger whose instant falls in the LED settling region, next to the turn-off edge, or before the guard has expired. When the run request drops, the current cycle finishes and the LEDs then stay dark.

Top module: `led_slot_seq`

## Requirements
- R1: After a start, slots follow each other in the order red (red LED on), ambient A (both LEDs off), infrared (infrared LED on), then ambient B when enabled. Every slot lasts cfg_slot_len cycles, and the order repeats without gaps while run_req is high.
- R2: In the red and infrared slots a single one-cycle adc_trig fires at cycle offset cfg_smp_ofs from slot start, with trig_tag 0 for red and 1 for infrared.
- R3: In each ambient slot a single one-cycle adc_trig fires at offset max(cfg_amb_ofs, cfg_guard), with both LEDs off and trig_tag 2 for ambient A or 3 for ambient B.
- R4: The ambient B slot exists only when cfg_amb2_en was 1 at start. Otherwise a red slot follows the infrared slot directly.
- R5: A start is accepted only when cfg_slot_len >= cfg_settle + 2 (one sample cycle plus one margin cycle) and cfg_smp_ofs, cfg_amb_ofs and cfg_guard are each below cfg_slot_len. Otherwise the sequencer stays idle with LEDs off and no triggers.
- R6: edge_flag is high exactly in trigger cycles where the LED sample offset is below cfg_settle or greater than cfg_slot_len - 2, or where the ambient offset is below cfg_guard.
- R7: Configuration is captured at start. Input changes while running do not alter slot length, offsets or order.
- R8: When run_req is low at the end of a cycle's last slot, the sequencer goes idle with both LEDs off and no triggers.
- R9: During and after reset both LED enables, adc_trig and edge_flag are low.
- R10: The two LED enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | High to run; low stops at the end of the cycle |
| cfg_slot_len | input | CNT_W | Slot width in cycles |
| cfg_settle | input | CNT_W | LED settling interval in cycles |
| cfg_smp_ofs | input | CNT_W | LED sample offset within a slot |
| cfg_amb_ofs | input | CNT_W | Ambient sample offset within an off slot |
| cfg_guard | input | CNT_W | Turn-off guard before an ambient sample |
| cfg_amb2_en | input | 1 | Enables the second ambient slot |
| led_red_en | output | 1 | Red LED enable |
| led_ir_en | output | 1 | Infrared LED enable |
| adc_trig | output | 1 | One-cycle ADC sample trigger |
| trig_tag | output | 2 | Slot tag of the trigger (0 red, 1 IR, 2 amb A, 3 amb B) |
| edge_flag | output | 1 | Sample instant lies in an edge, settling or guard region |

## Verification
The bound checker watches, in every cycle, that the LEDs are mutually exclusive, that red and infrared triggers come only with their own LED lit, that ambient triggers come only in darkness, that a dark slot always follows the red slot, and that the edge flag appears only with a trigger. Slot lengths, exact trigger offsets, the flag's conditions, refusal of bad settings, capture at start and the stop point can only be shown by the bench. It sweeps slot width, settle time and every sample offset against a cycle-accurate arithmetic model.

// File: rtl/led_slot_pkg.sv
package led_slot_pkg;
   typedef enum logic [1:0] {
      PH_RED  = 2'd0,
      PH_AMBA = 2'd1,
      PH_IR   = 2'd2,
      PH_AMBB = 2'd3
   } slot_ph_e;

   typedef enum logic [1:0] {
      TAG_RED  = 2'd0,
      TAG_IR   = 2'd1,
      TAG_AMBA = 2'd2,
      TAG_AMBB = 2'd3
   } slot_tag_e;
endpackage

// File: rtl/slot_cfg_check.sv
module slot_cfg_check #(
   parameter int CNT_W   = 16,
   parameter int SMP_CYC = 1,
   parameter int MARGIN  = 1
) (
   input  logic [CNT_W-1:0] slot_len,
   input  logic [CNT_W-1:0] settle,
   input  logic [CNT_W-1:0] smp_ofs,
   input  logic [CNT_W-1:0] amb_ofs,
   input  logic [CNT_W-1:0] guard,
   output logic             cfg_ok
);
   localparam int SW = CNT_W + 2;

   logic [SW-1:0] need;

   always_comb begin
      need   = SW'(settle) + SW'(SMP_CYC) + SW'(MARGIN);
      cfg_ok = (SW'(slot_len) >= need) && (smp_ofs < slot_len)
               && (amb_ofs < slot_len) && (guard < slot_len);
   end
endmodule

// File: rtl/slot_timer.sv
module slot_timer
   import led_slot_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter bit AMB2_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             run_req,
   input  logic             amb2_en,
   input  logic [CNT_W-1:0] slot_len,
   output logic             active,
   output slot_ph_e         phase,
   output logic [CNT_W-1:0] cnt
);
   logic amb2_use;
   logic last_cnt;
   logic last_ph;

   generate
      if (AMB2_SUPPORT) begin : g_amb2
         assign amb2_use = amb2_en;
      end else begin : g_no_amb2
         logic unused_en;
         assign unused_en = amb2_en;
         assign amb2_use  = 1'b0;
      end
   endgenerate

   assign last_cnt = (cnt == slot_len - CNT_W'(1));
   assign last_ph  = (phase == PH_AMBB) || ((phase == PH_IR) && !amb2_use);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= PH_RED;
         cnt    <= '0;
      end else if (!active) begin
         cnt   <= '0;
         phase <= PH_RED;
         if (go) active <= 1'b1;
      end else if (last_cnt) begin
         cnt <= '0;
         if (last_ph) begin
            phase  <= PH_RED;
            active <= run_req;
         end else begin
            phase <= slot_ph_e'(phase + 2'd1);
         end
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/slot_trig_gen.sv
module slot_trig_gen
   import led_slot_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int MARGIN = 1
) (
   input  logic             active,
   input  slot_ph_e         phase,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] slot_len,
   input  logic [CNT_W-1:0] settle,
   input  logic [CNT_W-1:0] smp_ofs,
   input  logic [CNT_W-1:0] amb_ofs,
   input  logic [CNT_W-1:0] guard,
   output logic             led_red_en,
   output logic             led_ir_en,
   output logic             adc_trig,
   output logic [1:0]       trig_tag,
   output logic             edge_flag
);
   localparam int SW = CNT_W + 1;

   logic             is_led;
   logic             led_edge;
   logic             amb_edge;
   logic [CNT_W-1:0] amb_at;
   logic             hit;

   always_comb begin
      is_led   = (phase == PH_RED) || (phase == PH_IR);
      led_edge = (smp_ofs < settle)
                 || ((SW'(smp_ofs) + SW'(MARGIN)) >= SW'(slot_len));
      amb_edge = (amb_ofs < guard);
      amb_at   = (guard > amb_ofs) ? guard : amb_ofs;
      hit      = is_led ? (cnt == smp_ofs) : (cnt == amb_at);

      led_red_en = active && (phase == PH_RED);
      led_ir_en  = active && (phase == PH_IR);
      adc_trig   = active && hit;
      edge_flag  = adc_trig && (is_led ? led_edge : amb_edge);

      unique case (phase)
         PH_RED:  trig_tag = TAG_RED;
         PH_IR:   trig_tag = TAG_IR;
         PH_AMBA: trig_tag = TAG_AMBA;
         default: trig_tag = TAG_AMBB;
      endcase
      if (!adc_trig) trig_tag = 2'd0;
   end
endmodule

// File: rtl/led_slot_seq.sv
module led_slot_seq
   import led_slot_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int SMP_CYC      = 1,
   parameter int MARGIN       = 1,
   parameter bit AMB2_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic [CNT_W-1:0] cfg_slot_len,
   input  logic [CNT_W-1:0] cfg_settle,
   input  logic [CNT_W-1:0] cfg_smp_ofs,
   input  logic [CNT_W-1:0] cfg_amb_ofs,
   input  logic [CNT_W-1:0] cfg_guard,
   input  logic             cfg_amb2_en,
   output logic             led_red_en,
   output logic             led_ir_en,
   output logic             adc_trig,
   output logic [1:0]       trig_tag,
   output logic             edge_flag
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("led_slot_seq: CNT_W must lie in 2..32");
      end
      if (SMP_CYC < 1) begin : g_bad_smp
         $error("led_slot_seq: SMP_CYC must be at least 1");
      end
   endgenerate

   logic             cfg_ok;
   logic             active;
   logic             go;
   slot_ph_e         phase;
   logic [CNT_W-1:0] cnt;

   logic [CNT_W-1:0] sh_len, sh_settle, sh_smp, sh_amb, sh_guard;
   logic             sh_amb2;

   slot_cfg_check #(.CNT_W(CNT_W), .SMP_CYC(SMP_CYC), .MARGIN(MARGIN)) u_cfg (
      .slot_len (cfg_slot_len),
      .settle   (cfg_settle),
      .smp_ofs  (cfg_smp_ofs),
      .amb_ofs  (cfg_amb_ofs),
      .guard    (cfg_guard),
      .cfg_ok   (cfg_ok)
   );

   assign go = !active && run_req && cfg_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_len    <= CNT_W'(2);
         sh_settle <= '0;
         sh_smp    <= '0;
         sh_amb    <= '0;
         sh_guard  <= '0;
         sh_amb2   <= 1'b0;
      end else if (go) begin
         sh_len    <= cfg_slot_len;
         sh_settle <= cfg_settle;
         sh_smp    <= cfg_smp_ofs;
         sh_amb    <= cfg_amb_ofs;
         sh_guard  <= cfg_guard;
         sh_amb2   <= cfg_amb2_en;
      end
   end

   slot_timer #(.CNT_W(CNT_W), .AMB2_SUPPORT(AMB2_SUPPORT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .run_req  (run_req),
      .amb2_en  (sh_amb2),
      .slot_len (sh_len),
      .active   (active),
      .phase    (phase),
      .cnt      (cnt)
   );

   slot_trig_gen #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u_trig (
      .active     (active),
      .phase      (phase),
      .cnt        (cnt),
      .slot_len   (sh_len),
      .settle     (sh_settle),
      .smp_ofs    (sh_smp),
      .amb_ofs    (sh_amb),
      .guard      (sh_guard),
      .led_red_en (led_red_en),
      .led_ir_en  (led_ir_en),
      .adc_trig   (adc_trig),
      .trig_tag   (trig_tag),
      .edge_flag  (edge_flag)
   );
endmodule

// File: rtl/led_slot_seq_chk.sv
module led_slot_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       led_red_en,
   input logic       led_ir_en,
   input logic       adc_trig,
   input logic [1:0] trig_tag,
   input logic       edge_flag
);
   assert_leds_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({led_red_en, led_ir_en}));

   assert_red_trig_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_trig && trig_tag == 2'd0) |-> led_red_en);

   assert_ir_trig_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_trig && trig_tag == 2'd1) |-> led_ir_en);

   assert_amb_trig_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_trig && trig_tag[1]) |-> (!led_red_en && !led_ir_en));

   assert_gap_after_red_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(led_red_en) |-> !led_ir_en);

   assert_flag_needs_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_flag |-> adc_trig);
endmodule

bind led_slot_seq led_slot_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .led_red_en (led_red_en),
   .led_ir_en  (led_ir_en),
   .adc_trig   (adc_trig),
   .trig_tag   (trig_tag),
   .edge_flag  (edge_flag)
);

// File: tb/test_led_slot_seq.sv
module test_led_slot_seq;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run_req = 1'b0;
   logic [W-1:0] cfg_slot_len = 16'd4;
   logic [W-1:0] cfg_settle = '0;
   logic [W-1:0] cfg_smp_ofs = '0;
   logic [W-1:0] cfg_amb_ofs = '0;
   logic [W-1:0] cfg_guard = '0;
   logic         cfg_amb2_en = 1'b0;
   logic         led_red_en, led_ir_en, adc_trig, edge_flag;
   logic [1:0]   trig_tag;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   led_slot_seq i_led_slot_seq (
      .clk(clk), .rst_n(rst_n), .run_req(run_req),
      .cfg_slot_len(cfg_slot_len), .cfg_settle(cfg_settle),
      .cfg_smp_ofs(cfg_smp_ofs), .cfg_amb_ofs(cfg_amb_ofs),
      .cfg_guard(cfg_guard), .cfg_amb2_en(cfg_amb2_en),
      .led_red_en(led_red_en), .led_ir_en(led_ir_en),
      .adc_trig(adc_trig), .trig_tag(trig_tag), .edge_flag(edge_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_idle(input string req);
      check(req, {led_red_en, led_ir_en, adc_trig, edge_flag}, 0);
   endtask

   task automatic run_cfg(input int L, input int T, input int S,
                          input int A, input int G, input bit a2);
      int  P;
      int  at;
      bit  ok;
      @(negedge clk);
      cfg_slot_len = W'(L); cfg_settle = W'(T); cfg_smp_ofs = W'(S);
      cfg_amb_ofs = W'(A); cfg_guard = W'(G); cfg_amb2_en = a2;
      ok = (L >= T + 2) && (S < L) && (A < L) && (G < L);
      run_req = 1'b1;
      if (!ok) begin
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_idle("R5");
         end
         run_req = 1'b0;
         return;
      end
      P  = a2 ? 4 * L : 3 * L;
      at = (G > A) ? G : A;
      for (int k = 0; k < 2 * P; k++) begin
         int  p, o;
         bit  etrig, eflag;
         int  etag;
         string rq;
         @(negedge clk);
         p = (k % P) / L;
         o = k % L;
         rq = (p == 3) ? "R4" : "R1";
         check(rq, {led_red_en, led_ir_en}, {p == 0, p == 2});
         etrig = (p % 2 == 0) ? (o == S) : (o == at);
         etag  = (p == 0) ? 0 : (p == 2) ? 1 : (p == 1) ? 2 : 3;
         eflag = etrig && ((p % 2 == 0) ? ((S < T) || (S > L - 2)) : (A < G));
         rq = (p % 2 == 0) ? "R2" : "R3";
         check(rq, {adc_trig, adc_trig ? trig_tag : 2'd0},
                   {etrig, etrig ? 2'(etag) : 2'd0});
         check("R6", edge_flag, eflag);
         if (!a2 && k == 3 * L) check("R4", led_red_en, 1);
         if (k == P) check("R7", led_red_en, 1);
         if (k == 2) begin
            cfg_slot_len = W'(L + 3); cfg_smp_ofs = '0;
            cfg_amb_ofs = W'(1); cfg_guard = '0; cfg_amb2_en = ~a2;
         end
         if (k == P) run_req = 1'b0;
      end
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_idle("R8");
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R9");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R9");
      for (int L = 4; L <= 6; L++) begin
         for (int ti = 0; ti < 4; ti++) begin
            int T;
            T = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? 3 : 5;
            for (int S = 0; S < L; S++) begin
               for (int ai = 0; ai < 3; ai++) begin
                  for (int gi = 0; gi < 3; gi++) begin
                     int A, G;
                     A = (ai == 0) ? 0 : (ai == 1) ? 1 : L - 1;
                     G = (gi == 0) ? 0 : (gi == 1) ? 2 : L - 1;
                     run_cfg(L, T, S, A, G, ((S + ai + gi) % 2) == 1);
                  end
               end
            end
         end
      end
      run_cfg(4, 0, 1, 4, 0, 1'b0);
      run_cfg(4, 0, 1, 0, 4, 1'b1);
      run_cfg(4, 0, 4, 0, 0, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule